// File: doc/BRIEF.md
# Register Dependence Interlock Unit

This block detects read-after-write hazards for a five-stage in-order integer pipeline that has no forwarding paths. It inspects the instruction currently in decode, works out which of its two source register fields it actually reads, and compares them against the destinations of the instructions still in flight in execute, memory and writeback. Each in-flight instruction is tracked by a small record: a valid bit, a write enable and a destination index.

When a live source matches a pending write, the block raises `stall`. The surrounding pipeline holds the program counter, the fetch register and the decode register for that cycle, and the unit itself loads a bubble into its execute record. A bubble is invalid and never writes. Once every pending writer of a needed register has left writeback, the stall drops and the held instruction enters execute.

Read and write enables are derived from the opcode class. A destination of register zero is filtered out. As a result, a field match alone does not cause a stall.

Top module: `hazard_interlock`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `stall` is 0 and `exValid` is 0.
- R2: Opcode 7'h6F (jump-and-link) always writes register 1, whatever bits [11:7] hold. A later read of register 1 stalls, and a read of the register named in bits [11:7] does not.
- R3: Opcodes 7'h33 (register ALU), 7'h13 (immediate ALU), 7'h03 (load) and 7'h67 (register jump-and-link) write the register in bits [11:7] only when that index is nonzero. A zero destination never causes a stall, and it shows `exWe` = 0.
- R4: Opcodes 7'h23 (store), 7'h63 (conditional branch) and 7'h0B (plain jump) write no register. A later read of their bits [11:7] value does not stall. A load after a store to the same address does not stall.
- R5: The first source, bits [19:15], is read by opcodes 7'h33, 7'h13, 7'h03, 7'h23, 7'h63 and 7'h67. It is ignored by 7'h0B and 7'h6F.
- R6: The second source, bits [24:20], is read only by opcodes 7'h33, 7'h23 and 7'h63.
- R7: `stall` is asserted combinationally when a read source equals the destination of a valid writing instruction in execute, memory or writeback. With no forwarding, a dependent instruction right after its producer stalls 3 cycles. With one independent instruction between them it stalls 2 cycles, with two it stalls 1, and with three it does not stall.
- R8: Each stalled cycle loads a bubble into execute, so `exValid` is 0 in the following cycle. The held instruction enters execute on the first cycle without a stall, and `exDest` and `exWe` then show its destination and write enable.
- R9: When `decValid` is 0, `stall` is 0 and no valid instruction enters execute. Bubbles and empty stages never cause a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode register holds a real instruction |
| decInstr | input | 32 | Instruction word in decode |
| stall | output | 1 | Hold fetch and decode, inject a bubble into execute |
| exValid | output | 1 | Execute stage holds a real instruction |
| exDest | output | 5 | Destination index tracked for the execute stage |
| exWe | output | 1 | Execute-stage instruction writes a register |

## Verification
The bench builds the unit with its defaults: three pending stages compared, 5-bit register indices and register 1 as the link target. The three-stage window lets the producer-to-consumer distance be swept from zero to three intervening instructions. This shows the stall length falling from three cycles to none. Because the link register differs from register zero and from any test destination, the fixed jump-and-link destination can be told apart from its bits [11:7].

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  parameter int unsigned REG_W = 5;

  // opcode classes (bits [6:0])
  localparam logic [6:0] OpAlu    = 7'h33;
  localparam logic [6:0] OpAluImm = 7'h13;
  localparam logic [6:0] OpLoad   = 7'h03;
  localparam logic [6:0] OpStore  = 7'h23;
  localparam logic [6:0] OpBranch = 7'h63;
  localparam logic [6:0] OpJump   = 7'h0B;
  localparam logic [6:0] OpJal    = 7'h6F;
  localparam logic [6:0] OpJalr   = 7'h67;

  // field positions
  localparam int unsigned OpLsb  = 0;
  localparam int unsigned RdLsb  = 7;
  localparam int unsigned Rs1Lsb = 15;
  localparam int unsigned Rs2Lsb = 20;

  typedef struct packed {
    logic             valid;
    logic             we;
    logic [REG_W-1:0] dest;
  } stageInfo_t;

  typedef struct packed {
    logic stall;
    logic issue;
  } ilkCtl_t;
endpackage

// File: rtl/ilk_control.sv
module ilk_control
  import ilk_pkg::*;
#(
  parameter int unsigned ILEN     = 32,
  parameter int unsigned PEND     = 3,
  parameter int unsigned LINK_REG = 1
) (
  input  logic                  decValid,
  input  logic [ILEN-1:0]       decInstr,
  input  stageInfo_t [PEND-1:0] pend,
  output stageInfo_t            decInfo,
  output ilkCtl_t               ctl
);
  logic [6:0]       opcode;
  logic [REG_W-1:0] rdField, rs1, rs2;
  logic             readA, readB, writes;
  logic [REG_W-1:0] dest;
  logic [PEND-1:0]  hitA, hitB;
  logic             unusedBits;

  assign opcode  = decInstr[OpLsb +: 7];
  assign rdField = decInstr[RdLsb +: REG_W];
  assign rs1     = decInstr[Rs1Lsb +: REG_W];
  assign rs2     = decInstr[Rs2Lsb +: REG_W];
  assign unusedBits = ^{decInstr[ILEN-1:Rs2Lsb+REG_W], decInstr[Rs1Lsb-1:RdLsb+REG_W]};

  always_comb begin
    readA  = 1'b0;
    readB  = 1'b0;
    writes = 1'b0;
    dest   = rdField;
    unique case (opcode)
      OpAlu: begin
        readA  = 1'b1;
        readB  = 1'b1;
        writes = (rdField != '0);
      end
      OpAluImm, OpLoad, OpJalr: begin
        readA  = 1'b1;
        writes = (rdField != '0);
      end
      OpStore, OpBranch: begin
        readA = 1'b1;
        readB = 1'b1;
      end
      OpJal: begin
        dest   = REG_W'(LINK_REG);
        writes = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < PEND; i++) begin : g_cmp
    assign hitA[i] = pend[i].valid && pend[i].we && (pend[i].dest == rs1);
    assign hitB[i] = pend[i].valid && pend[i].we && (pend[i].dest == rs2);
  end

  assign ctl.stall = decValid && ((readA && |hitA) || (readB && |hitB));
  assign ctl.issue = decValid && !ctl.stall;

  assign decInfo.valid = decValid;
  assign decInfo.we    = decValid && writes;
  assign decInfo.dest  = dest;
endmodule

// File: rtl/ilk_stages.sv
module ilk_stages
  import ilk_pkg::*;
#(
  parameter int unsigned PEND = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ilkCtl_t               ctl,
  input  stageInfo_t            decInfo,
  output stageInfo_t [PEND-1:0] pend
);
  stageInfo_t [PEND-1:0] q;

  always_ff @(posedge clk) begin
    if (!rstN)          q[0] <= '0;
    else if (ctl.issue) q[0] <= decInfo;
    else                q[0] <= '0;
  end

  for (genvar i = 1; i < PEND; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rstN) q[i] <= '0;
      else       q[i] <= q[i-1];
    end
  end

  assign pend = q;
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned ILEN     = 32,
  parameter int unsigned PEND     = 3,
  parameter int unsigned LINK_REG = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic [ILEN-1:0]  decInstr,
  output logic             stall,
  output logic             exValid,
  output logic [REG_W-1:0] exDest,
  output logic             exWe
);
  stageInfo_t [PEND-1:0] pend;
  stageInfo_t            decInfo;
  ilkCtl_t               ctl;

  ilk_control #(.ILEN(ILEN), .PEND(PEND), .LINK_REG(LINK_REG)) u_ctl (
    .decValid(decValid), .decInstr(decInstr), .pend(pend),
    .decInfo(decInfo), .ctl(ctl)
  );

  ilk_stages #(.PEND(PEND)) u_stg (
    .clk(clk), .rstN(rstN), .ctl(ctl), .decInfo(decInfo), .pend(pend)
  );

  assign stall   = ctl.stall;
  assign exValid = pend[0].valid;
  assign exDest  = pend[0].dest;
  assign exWe    = pend[0].we;
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
  parameter int unsigned PEND  = 3,
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             decValid,
  input logic             stall,
  input logic             exValid,
  input logic [REG_W-1:0] exDest,
  input logic             exWe
);
  logic [7:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                      runCnt <= '0;
    else if (!stall)                runCnt <= '0;
    else if (runCnt != 8'hFF)       runCnt <= runCnt + 8'd1;
  end

  a_r8_bubble_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !exValid);

  a_r8_issue_when_free: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !stall) |=> exValid);

  a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !stall);

  a_r9_bubble_silent: assert property (@(posedge clk) disable iff (!rstN)
    !exValid |-> !exWe);

  a_r3_zero_dest_silent: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exDest == '0) |-> !exWe);

  a_r7_stall_window: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (runCnt < 8'(PEND)));
endmodule

bind hazard_interlock hazard_interlock_chk #(.PEND(PEND), .REG_W(ilk_pkg::REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .stall(stall),
  .exValid(exValid), .exDest(exDest), .exWe(exWe)
);

// File: tb/hazard_interlock_test.sv
`timescale 1ns/1ps
module hazard_interlock_test;
  localparam logic [6:0] ALU = 7'h33, ALUI = 7'h13, LD = 7'h03, ST = 7'h23;
  localparam logic [6:0] BR = 7'h63, JMP = 7'h0B, JAL = 7'h6F, JALR = 7'h67;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        decValid = 1'b0;
  logic [31:0] decInstr = '0;
  logic        stall, exValid, exWe;
  logic [4:0]  exDest;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hazard_interlock uut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decInstr(decInstr),
    .stall(stall), .exValid(exValid), .exDest(exDest), .exWe(exWe)
  );

  function automatic logic [31:0] enc(input logic [6:0] op, input int rd,
                                      input int rs1, input int rs2);
    return {7'b0, 5'(rs2), 5'(rs1), 3'b0, 5'(rd), op};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one decode instruction, count stalled cycles, then check execute entry
  task automatic issue(input logic [31:0] ins, input int expStall,
                       input int expDest, input bit expWe, input string req);
    int n = 0;
    decValid = 1'b1;
    decInstr = ins;
    #1;
    while (stall && n < 8) begin
      @(negedge clk); #1;
      n++;
      check(exValid == 1'b0, "R8 bubble", exValid, 0);
    end
    check(n == expStall, req, n, expStall);
    @(negedge clk); #1;
    check(exValid == 1'b1 && exDest == 5'(expDest) && exWe == expWe,
          {req, " exec entry"}, {exValid, exWe, exDest}, {1'b1, expWe, 5'(expDest)});
  endtask

  task automatic idle(input int cycles);
    decValid = 1'b0;
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    check(stall == 0 && exValid == 0, "R1 in reset", {stall, exValid}, 0);
    @(negedge clk); rstN = 1'b1; #1;
    check(stall == 0 && exValid == 0, "R1 after release", {stall, exValid}, 0);
    @(negedge clk);
  endtask

  task automatic t_back_to_back;
    issue(enc(ALU, 3, 1, 2), 0, 3, 1, "R7 producer");
    issue(enc(ALU, 4, 3, 0), 3, 4, 1, "R7 back-to-back 3 stalls");
    idle(4);
  endtask

  task automatic t_gaps;
    for (int g = 1; g <= 3; g++) begin
      issue(enc(ALU, 3, 1, 2), 0, 3, 1, "R7 producer");
      for (int f = 0; f < g; f++) issue(enc(ALU, 6, 7, 8), 0, 6, 1, "R7 filler");
      issue(enc(ALU, 5, 0, 3), 3 - g, 5, 1, "R7 gap stall count");
      idle(4);
    end
  endtask

  task automatic t_writers;
    issue(enc(LD, 9, 0, 0), 0, 9, 1, "R3 load");
    issue(enc(ALUI, 15, 9, 0), 3, 15, 1, "R3 load dependence");
    idle(4);
    issue(enc(JALR, 10, 0, 0), 0, 10, 1, "R3 jalr");
    issue(enc(ALU, 16, 0, 10), 3, 16, 1, "R3 jalr dependence");
    idle(4);
    issue(enc(ALUI, 0, 1, 0), 0, 0, 0, "R3 zero destination no write");
    issue(enc(ALU, 17, 0, 0), 0, 17, 1, "R3 read x0 no stall");
    idle(4);
  endtask

  task automatic t_link;
    issue(enc(JAL, 5, 0, 0), 0, 1, 1, "R2 jal dest is link");
    issue(enc(ALU, 11, 5, 0), 0, 11, 1, "R2 rd field not written");
    issue(enc(ALU, 12, 1, 0), 2, 12, 1, "R2 link read stalls");
    idle(4);
  endtask

  task automatic t_nonwriters;
    issue(enc(ST, 5, 2, 0), 0, 5, 0, "R4 store no write");
    issue(enc(ALU, 18, 5, 0), 0, 18, 1, "R4 after store");
    idle(4);
    issue(enc(BR, 6, 0, 0), 0, 6, 0, "R4 branch no write");
    issue(enc(ALU, 18, 6, 0), 0, 18, 1, "R4 after branch");
    idle(4);
    issue(enc(JMP, 7, 0, 0), 0, 7, 0, "R4 jump no write");
    issue(enc(ALU, 18, 0, 7), 0, 18, 1, "R4 after jump");
    idle(4);
    issue(enc(ST, 5, 13, 2), 0, 5, 0, "R4 store");
    issue(enc(LD, 12, 13, 0), 0, 12, 1, "R4 load after store same address");
    idle(4);
  endtask

  task automatic t_reads;
    issue(enc(ALU, 3, 1, 2), 0, 3, 1, "R5 producer");
    issue(enc(JMP, 0, 3, 0), 0, 0, 0, "R5 jump ignores rs1");
    issue(enc(JAL, 0, 3, 0), 0, 1, 1, "R5 jal ignores rs1");
    issue(enc(ST, 0, 3, 0), 1, 0, 0, "R5 store reads rs1");
    idle(4);
    issue(enc(ALU, 3, 1, 2), 0, 3, 1, "R6 producer");
    issue(enc(ALUI, 14, 0, 3), 0, 14, 1, "R6 immediate ignores rs2");
    issue(enc(ST, 0, 0, 3), 2, 0, 0, "R6 store reads rs2");
    idle(4);
    issue(enc(ALU, 3, 1, 2), 0, 3, 1, "R6 producer");
    issue(enc(BR, 0, 0, 3), 3, 0, 0, "R6 branch reads rs2");
    idle(4);
  endtask

  task automatic t_idle;
    issue(enc(ALU, 3, 1, 2), 0, 3, 1, "R9 producer");
    decValid = 1'b0;
    decInstr = enc(ALU, 4, 3, 3);
    #1;
    check(stall == 0, "R9 invalid decode no stall", stall, 0);
    @(negedge clk); #1;
    check(exValid == 0, "R9 invalid decode not issued", exValid, 0);
    issue(enc(ALU, 4, 3, 0), 2, 4, 1, "R9 dependence across empty slot");
    idle(4);
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_gaps();
    t_writers();
    t_link();
    t_nonwriters();
    t_reads();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule